// File: doc/BRIEF.md
# Power-Loss Safe Sequencing Controller

This controller steps a battery-less cryptographic tag through each power-up. It holds the engine in reset until the backup capacitor is charged, then asks for the separate non-volatile rail. Once that rail is ready it restores saved state and runs a key update. Only after that update does it open the challenge-response window. When power is lost it backs the state up and acknowledges shutdown. The analog side (capacitors, rails, non-volatile cells) and the crypto engine are outside the block and are seen only as level handshakes. There is no data path, so every pin is a plain control or status level.

What happens when power drops depends on the phase it drops in:
- Before the rail is ready, nothing non-volatile has been touched, so the controller just shuts down.
- During a restore, it finishes the restore, forces one complete key update and backs up, all on stored energy.
- During a normal key update, it saves an "update pending" flag so the next power-up resumes the update.
- During the challenge window or an encryption, the encryption is dropped and the next power-up starts a fresh update.

The persistent image holds a key index and the pending flag. Its seed value (index `SEED_IDX`, pending 0) is loaded by `rst_n`, which stands for manufacture. Between glitches it changes only at the end of a backup.

Top module: `pls_seq_ctrl`

## Requirements
- R1: `rst_release_o` stays 0 while the synchronised capacitor-charged input is 0 after a power-up, and stays 0 throughout shutdown.
- R2: `rail_req_o` rises after reset release. `restore_go_o` does not rise until the synchronised rail-ready input is 1.
- R3: A power loss before the restore begins leads to `shdn_ack_o` without any restore or backup. The persistent image is left unchanged.
- R4: A power loss during a restore does not stop it. The controller then runs one full key update and backs up without ever opening the challenge window. The persistent index ends one higher, with pending 0.
- R5: `chal_ready_o` and `enc_en_o` become 1 only after the key update of the current power-up has completed.
- R6: A power loss during a normal key update goes straight to backup, stores pending 1 and leaves the index unchanged. `keyupd_resume_o` during a key update equals the restored pending flag (1 = resume, 0 = fresh start).
- R7: A power loss in the challenge window or during encryption drops `enc_en_o` and backs up. The stored image is the incremented index with pending 0.
- R8: Power-loss events during a backup are ignored, and `backup_go_o` holds until `backup_done_i`. No new power-up (`rst_release_o` = 1) occurs until shutdown has completed and power is back.
- R9: Each completed key update raises `key_idx_o` by exactly one. The persistent index `nv_key_idx_o` takes the working value only at the end of a backup.
- R10: `pwr_lost_i` passes through a two-flop synchroniser. A loss pulse that spans at least one clock edge is latched until the sequence acknowledges it, so a brief glitch is still acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also seeds the persistent image |
| cap_charged_i | input | 1 | Backup capacitor at target level (asynchronous) |
| nv_rail_ok_i | input | 1 | Non-volatile rail ready (asynchronous) |
| pwr_lost_i | input | 1 | Harvested power lost (asynchronous) |
| restore_done_i | input | 1 | Restore of non-volatile state finished |
| keyupd_done_i | input | 1 | Key update finished |
| chal_req_i | input | 1 | Challenge present, start encryption |
| enc_done_i | input | 1 | Encryption finished |
| backup_done_i | input | 1 | Backup to non-volatile cells finished |
| rst_release_o | output | 1 | Engine reset released |
| rail_req_o | output | 1 | Request charge of the non-volatile rail |
| restore_go_o | output | 1 | Restore in progress |
| keyupd_go_o | output | 1 | Key update in progress |
| keyupd_resume_o | output | 1 | Key update resumes an interrupted one |
| chal_ready_o | output | 1 | Challenge-response window open |
| enc_en_o | output | 1 | Encryption enabled |
| backup_go_o | output | 1 | Backup in progress |
| shdn_ack_o | output | 1 | Safe shutdown reached |
| key_idx_o | output | KIDX_W | Working key index |
| nv_key_idx_o | output | KIDX_W | Persistent key index |
| nv_pend_o | output | 1 | Persistent update-pending flag |

## Verification
The hardest situation to reach from the ports is a loss that arrives in the middle of a restore and is already gone by the time the restore finishes. The controller has to remember it and still finish on stored energy. The bench plays the crypto engine itself: it holds back `restore_done_i`, fires a three-cycle loss pulse, releases power again and only then completes the restore. It then checks that the forced update and backup follow without the challenge window opening. The bench also chains power-ups with losses in randomly chosen phases, so that resume and restart cases follow one another, and it re-toggles power during every backup.

// File: rtl/pls_pkg.sv
package pls_pkg;
  typedef enum logic [2:0] {
    PH_HOLD, PH_RAIL, PH_RESTORE, PH_KEYUPD,
    PH_READY, PH_ENCRYPT, PH_BACKUP, PH_SHDN
  } phase_e;
endpackage

// File: rtl/pls_sync.sv
module pls_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pls_loss_latch.sv
module pls_loss_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic loss_s,
  input  logic ack,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (ack)    pend <= 1'b0;
    else if (loss_s) pend <= 1'b1;
  end

  AST_LOSS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_s || pend) && !ack |=> pend); // R10
endmodule

// File: rtl/pls_nv_image.sv
module pls_nv_image #(
  parameter int KIDX_W   = 16,
  parameter int SEED_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              bump,
  input  logic              mark,
  input  logic              commit,
  output logic [KIDX_W-1:0] work_idx,
  output logic              work_pend,
  output logic [KIDX_W-1:0] nv_idx,
  output logic              nv_pend
);
  localparam logic [KIDX_W-1:0] SEED = KIDX_W'(SEED_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_idx  <= SEED;
      work_pend <= 1'b0;
    end else if (load) begin
      work_idx  <= nv_idx;
      work_pend <= nv_pend;
    end else if (bump) begin
      work_idx  <= work_idx + 1'b1;
      work_pend <= 1'b0;
    end else if (mark) begin
      work_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_idx  <= SEED;
      nv_pend <= 1'b0;
    end else if (commit) begin
      nv_idx  <= work_idx;
      nv_pend <= work_pend;
    end
  end
endmodule

// File: rtl/pls_seq_fsm.sv
module pls_seq_fsm
  import pls_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cap_s,
  input  logic   rail_s,
  input  logic   pwr_s,
  input  logic   loss_pend,
  input  logic   restore_done,
  input  logic   keyupd_done,
  input  logic   chal_req,
  input  logic   enc_done,
  input  logic   backup_done,
  output phase_e phase,
  output logic   emerg,
  output logic   ack,
  output logic   load,
  output logic   bump,
  output logic   mark,
  output logic   commit
);
  phase_e nxt;
  logic   emerg_d;

  always_comb begin
    nxt     = phase;
    emerg_d = emerg;
    ack     = 1'b0;
    load    = 1'b0;
    bump    = 1'b0;
    mark    = 1'b0;
    commit  = 1'b0;
    unique case (phase)
      PH_HOLD: begin
        if (loss_pend) begin
          ack = 1'b1;
          nxt = PH_SHDN;
        end else if (cap_s) begin
          nxt = PH_RAIL;
        end
      end
      PH_RAIL: begin
        if (loss_pend) begin
          ack = 1'b1;
          nxt = PH_SHDN;
        end else if (rail_s) begin
          nxt = PH_RESTORE;
        end
      end
      PH_RESTORE: begin
        if (loss_pend) begin
          ack     = 1'b1;
          emerg_d = 1'b1;
        end
        if (restore_done) begin
          load = 1'b1;
          nxt  = PH_KEYUPD;
        end
      end
      PH_KEYUPD: begin
        if (emerg) begin
          ack = loss_pend;
          if (keyupd_done) begin
            bump = 1'b1;
            nxt  = PH_BACKUP;
          end
        end else if (keyupd_done) begin
          bump = 1'b1;
          ack  = loss_pend;
          nxt  = loss_pend ? PH_BACKUP : PH_READY;
        end else if (loss_pend) begin
          mark = 1'b1;
          ack  = 1'b1;
          nxt  = PH_BACKUP;
        end
      end
      PH_READY: begin
        if (loss_pend) begin
          ack = 1'b1;
          nxt = PH_BACKUP;
        end else if (chal_req) begin
          nxt = PH_ENCRYPT;
        end
      end
      PH_ENCRYPT: begin
        if (loss_pend) begin
          ack = 1'b1;
          nxt = PH_BACKUP;
        end else if (enc_done) begin
          nxt = PH_READY;
        end
      end
      PH_BACKUP: begin
        ack = 1'b1;
        if (backup_done) begin
          commit  = 1'b1;
          emerg_d = 1'b0;
          nxt     = PH_SHDN;
        end
      end
      PH_SHDN: begin
        ack = 1'b1;
        if (!pwr_s) nxt = PH_HOLD;
      end
      default: nxt = PH_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_HOLD;
      emerg <= 1'b0;
    end else begin
      phase <= nxt;
      emerg <= emerg_d;
    end
  end

  AST_BACKUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BACKUP) && !backup_done |=> (phase == PH_BACKUP)); // R8

  AST_EMERG_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    emerg |-> (phase != PH_READY) && (phase != PH_ENCRYPT)); // R4

  AST_EMERG_FINISHES_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_KEYUPD) && emerg && !keyupd_done |=> (phase == PH_KEYUPD)); // R4
endmodule

// File: rtl/pls_seq_ctrl.sv
module pls_seq_ctrl
  import pls_pkg::*;
#(
  parameter int KIDX_W      = 16,
  parameter int SEED_IDX    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_charged_i,
  input  logic              nv_rail_ok_i,
  input  logic              pwr_lost_i,
  input  logic              restore_done_i,
  input  logic              keyupd_done_i,
  input  logic              chal_req_i,
  input  logic              enc_done_i,
  input  logic              backup_done_i,
  output logic              rst_release_o,
  output logic              rail_req_o,
  output logic              restore_go_o,
  output logic              keyupd_go_o,
  output logic              keyupd_resume_o,
  output logic              chal_ready_o,
  output logic              enc_en_o,
  output logic              backup_go_o,
  output logic              shdn_ack_o,
  output logic [KIDX_W-1:0] key_idx_o,
  output logic [KIDX_W-1:0] nv_key_idx_o,
  output logic              nv_pend_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] async_in, sync_out;
  logic cap_s, rail_s, pwr_s;
  logic loss_pend, ack, load, bump, mark, commit, emerg, work_pend;
  phase_e phase;

  assign async_in = {cap_charged_i, nv_rail_ok_i, pwr_lost_i};
  assign {cap_s, rail_s, pwr_s} = sync_out;

  pls_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
  );

  pls_loss_latch u_latch (
    .clk(clk), .rst_n(rst_n), .loss_s(pwr_s), .ack(ack), .pend(loss_pend)
  );

  pls_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cap_s(cap_s), .rail_s(rail_s), .pwr_s(pwr_s),
    .loss_pend(loss_pend), .restore_done(restore_done_i),
    .keyupd_done(keyupd_done_i), .chal_req(chal_req_i), .enc_done(enc_done_i),
    .backup_done(backup_done_i), .phase(phase), .emerg(emerg), .ack(ack),
    .load(load), .bump(bump), .mark(mark), .commit(commit)
  );

  pls_nv_image #(.KIDX_W(KIDX_W), .SEED_IDX(SEED_IDX)) u_image (
    .clk(clk), .rst_n(rst_n), .load(load), .bump(bump), .mark(mark),
    .commit(commit), .work_idx(key_idx_o), .work_pend(work_pend),
    .nv_idx(nv_key_idx_o), .nv_pend(nv_pend_o)
  );

  assign rst_release_o   = (phase != PH_HOLD) && (phase != PH_SHDN);
  assign rail_req_o      = rst_release_o;
  assign restore_go_o    = (phase == PH_RESTORE);
  assign keyupd_go_o     = (phase == PH_KEYUPD);
  assign keyupd_resume_o = keyupd_go_o && work_pend;
  assign chal_ready_o    = (phase == PH_READY);
  assign enc_en_o        = (phase == PH_ENCRYPT);
  assign backup_go_o     = (phase == PH_BACKUP);
  assign shdn_ack_o      = (phase == PH_SHDN);

  AST_RESTORE_AFTER_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_go_o) |-> $past(rail_s)); // R2

  AST_WINDOW_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chal_ready_o) |-> ($past(keyupd_go_o) || $past(enc_en_o))); // R5

  AST_RELEASE_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_release_o) |-> $past(cap_s)); // R1
endmodule

// File: tb/pls_seq_ctrl_bench.sv
module pls_seq_ctrl_bench;
  localparam int KW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap = 0, rail = 0, pwr = 0, rdone = 0, kdone = 0, chal = 0, edone = 0, bdone = 0;
  logic rel, rreq, rgo, kgo, kres, cready, enc, bgo, shdn, npend;
  logic [KW-1:0] kidx, nidx;

  int total = 0;
  int bad = 0;
  logic [KW-1:0] exp_idx = '0;
  logic exp_pend = 1'b0;

  always #10 clk = ~clk;

  pls_seq_ctrl #(.KIDX_W(KW)) u_pls_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_charged_i(cap), .nv_rail_ok_i(rail),
    .pwr_lost_i(pwr), .restore_done_i(rdone), .keyupd_done_i(kdone),
    .chal_req_i(chal), .enc_done_i(edone), .backup_done_i(bdone),
    .rst_release_o(rel), .rail_req_o(rreq), .restore_go_o(rgo),
    .keyupd_go_o(kgo), .keyupd_resume_o(kres), .chal_ready_o(cready),
    .enc_en_o(enc), .backup_go_o(bgo), .shdn_ack_o(shdn),
    .key_idx_o(kidx), .nv_key_idx_o(nidx), .nv_pend_o(npend)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit outv(input int s);
    case (s)
      0: return rreq;
      1: return rgo;
      2: return kgo;
      3: return cready;
      4: return enc;
      5: return bgo;
      default: return shdn;
    endcase
  endfunction

  task automatic wait_for(input int s, input string req);
    int n = 0;
    while (!outv(s) && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(n < 1000, req, 0, 1);
  endtask

  task automatic pulse(input int s);
    @(negedge clk);
    case (s)
      0: rdone = 1'b1;
      1: kdone = 1'b1;
      2: chal  = 1'b1;
      3: edone = 1'b1;
      default: bdone = 1'b1;
    endcase
    @(negedge clk);
    {rdone, kdone, chal, edone, bdone} = '0;
  endtask

  // Expected persistent image after a power-up whose loss hits phase ph
  // (0 hold, 1 rail, 2 restore, 3 key update, 4 window, 5 encryption).
  function automatic logic [KW:0] model_next(input int ph, input logic [KW-1:0] i, input logic p);
    case (ph)
      0, 1:    return {i, p};
      3:       return {i, 1'b1};
      default: return {i + 1'b1, 1'b0};
    endcase
  endfunction

  task automatic episode(input int ph);
    logic [KW:0] nx;
    cap = 0; rail = 0; pwr = 0;
    cyc(10);
    check(rel == 1'b0, "R1", rel, 0);
    if (ph == 0) begin
      pwr = 1'b1;
      wait_for(6, "R3");
    end else begin
      cap = 1'b1;
      wait_for(0, "R2");
      cyc(10);
      check(rgo == 1'b0, "R2", rgo, 0);
      if (ph == 1) begin
        pwr = 1'b1;
        wait_for(6, "R3");
      end else begin
        rail = 1'b1;
        wait_for(1, "R2");
        if (ph == 2) begin
          pwr = 1'b1;
          cyc(3);
          pwr = 1'b0;
          cyc(8);
          check(rgo == 1'b1, "R10", rgo, 1);
          pulse(0);
          wait_for(2, "R4");
          check(kres == exp_pend, "R6", kres, exp_pend);
          pulse(1);
          wait_for(5, "R4");
        end else begin
          pulse(0);
          wait_for(2, "R6");
          check(kres == exp_pend, "R6", kres, exp_pend);
          if (ph == 3) begin
            pwr = 1'b1;
            wait_for(5, "R6");
          end else begin
            check(cready == 1'b0 && enc == 1'b0, "R5", cready, 0);
            pulse(1);
            wait_for(3, "R5");
            check(kidx == exp_idx + 1'b1, "R9", kidx, exp_idx + 1);
            if (ph == 4) begin
              for (int k = 0; k < int'($urandom_range(0, 2)); k++) begin
                pulse(2);
                wait_for(4, "R5");
                cyc(3);
                pulse(3);
                wait_for(3, "R5");
              end
              pwr = 1'b1;
              wait_for(5, "R7");
            end else begin
              pulse(2);
              wait_for(4, "R5");
              cyc(2);
              pwr = 1'b1;
              wait_for(5, "R7");
              check(enc == 1'b0, "R7", enc, 0);
            end
          end
        end
        // backup phase: power returns and drops again, all ignored
        cap = 1'b0;
        pwr = 1'b0;
        cyc(12);
        check(bgo == 1'b1 && rel == 1'b1 && rgo == 1'b0, "R8", bgo, 1);
        pwr = 1'b1;
        cyc(3);
        pwr = 1'b0;
        cyc(10);
        check(bgo == 1'b1, "R8", bgo, 1);
        pwr = 1'b1;
        pulse(4);
        wait_for(6, "R8");
      end
    end
    nx = model_next(ph, exp_idx, exp_pend);
    cyc(5);
    check(nidx == nx[KW:1], "R9", nidx, nx[KW:1]);
    check(npend == nx[0], (ph == 3) ? "R6" : "R7", npend, nx[0]);
    check(rel == 1'b0 && shdn == 1'b1, "R8", rel, 0);
    exp_idx = nx[KW:1];
    exp_pend = nx[0];
    pwr = 1'b0; cap = 1'b0; rail = 1'b0;
    cyc(6);
    check(rel == 1'b0, "R1", rel, 0);
  endtask

  initial begin
    int dir [10] = '{0, 1, 2, 3, 3, 4, 5, 2, 3, 2};
    void'($urandom(32'h5eed_0042));
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    check(rel == 1'b0 && shdn == 1'b0 && nidx == '0 && npend == 1'b0, "R1", rel, 0);
    foreach (dir[i]) episode(dir[i]);
    for (int i = 0; i < 30; i++) episode(int'($urandom_range(0, 5)));
    finish_run();
  end
endmodule